// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Character FIFO

This block turns an asynchronous serial line into characters and holds them in a small first-in first-out store until a reader collects them. A set of static configuration inputs chooses how frames are taken in:
- whether the block runs at all;
- whether reception is on;
- 16x oversampled centre sampling or single sampling on an external bit clock;
- a seven- or eight-bit character;
- an optional parity bit and its sense;
- one or two stop bits.

Each stored character carries its own parity-error and framing-error flags. The block also reports a sticky overrun flag and three fill-level flags.

The reader sees the oldest character on the read outputs whenever the ready flag is high. A one-cycle read strobe removes it. Turning reception off empties the store. Dropping the unit enable freezes every register in place, as if the clock were stopped. The first read strobe after reset does not remove a character. It starts the store and the overrun flag from a clean state.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rdy, half, full and ovr are all 0.
- R2: While unit_en is 0 no register changes: the line, the read strobe and the receive enable have no effect, and the flags and read outputs keep their values.
- R3: While unit_en is 1 and rx_en is 0, the store is emptied, ovr is cleared and the line is ignored, so no character arrives.
- R4: With mode_1x = 0, a start bit is found at the first tick16 pulse that sees the line low. Each later bit is sampled 8 ticks after that detection and then every 16 ticks.
- R5: With mode_1x = 0, a start bit whose line is high again at its mid-sample is discarded and no character is stored.
- R6: With mode_1x = 1, the line is sampled once at each rising edge of bit_clk. A low sample while idle is taken as the start bit.
- R7: Data arrive least significant bit first. With eight_bit = 1 a character has 8 data bits. With eight_bit = 0 it has 7 data bits and rd_data[7] reads 0.
- R8: With par_en = 1, one parity bit follows the data. par_odd = 1 selects odd parity and par_odd = 0 selects even parity. rd_perr is 1 for a character whose parity does not match. With par_en = 0 no parity bit is taken and rd_perr is 0.
- R9: two_stop = 0 takes one stop bit and two_stop = 1 takes two. rd_ferr is 1 when any stop sample is low.
- R10: The store holds up to 8 characters in arrival order. rdy means at least 1 is held, half means at least 4, and full means 8. Each rd_stb removes the oldest character.
- R11: A character that completes while the store is full is discarded and sets ovr. ovr stays set until a read strobe removes a character, or the store is flushed.
- R12: The first rd_stb after reset empties the store and clears ovr without removing a character. Later strobes remove characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| bit_clk | input | 1 | External bit clock for 1x mode |
| unit_en | input | 1 | Global enable; 0 freezes the block |
| rx_en | input | 1 | Receive enable; 0 flushes and ignores the line |
| mode_1x | input | 1 | 1 = sample on bit_clk rising edge, 0 = 16x centre sampling |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| eight_bit | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| rd_stb | input | 1 | Read strobe, removes the oldest character |
| rd_data | output | 8 | Oldest character held, valid while rdy |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| ovr | output | 1 | Sticky overrun flag |
| rdy | output | 1 | At least one character held |
| half | output | 1 | At least half the store is occupied |
| full | output | 1 | Store completely occupied |

## Verification
The bench builds the block with its default parameters:
- a store 8 deep;
- 16 ticks per bit;
- a tick16 pulse every 4 clocks, which gives a 64-clock bit;
- a 32-clock bit clock.

These values make it cheap to sweep all 32 combinations of sampling mode, character length, parity enable, parity sense and stop count, with parity and stop faults injected on some of them. Nine back-to-back characters are enough to pass every fill-level boundary and to force an overrun.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver: the stored character record and
// the framer state encoding. Assumes a character of at most 8 data bits.
package srx_pkg;
    localparam int SRX_DW = 8;

    typedef struct packed {
        logic [SRX_DW-1:0] data;
        logic              perr;
        logic              ferr;
    } srx_char_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP1,
        FR_STOP2
    } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchronizer for an asynchronous input. It advances only while
// en is high, so the whole block freezes together. Assumes STAGES >= 2.
module srx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n)  chain <= {STAGES{RST_VAL}};
        else if (en) chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
// Frame recogniser. It finds the start bit, samples the data, parity and stop
// bits, and emits one registered push per finished character. In 16x mode it
// counts tick16 pulses from the start detection. In 1x mode it samples on
// rising edges of the synchronized bit clock. clr returns it to idle.
// Assumes the line and bit clock inputs are already synchronized.
module srx_framer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      clr,
    input  logic      mode_1x,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      two_stop,
    input  logic      eight_bit,
    input  logic      tick16,
    input  logic      line,
    input  logic      bclk,
    output logic      push,
    output srx_char_t push_char
);
    localparam int            CW  = $clog2(OVS);
    localparam int            BW  = $clog2(SRX_DW);
    localparam logic [CW-1:0] MID = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] END = CW'(OVS - 1);

    srx_state_t        state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitcnt;
    logic [SRX_DW-1:0] shreg;
    logic              pbit;
    logic              ferr_q;
    logic              bclk_q;
    logic              bclk_rise;
    logic [CW-1:0]     limit;
    logic              samp;
    logic              start_seen;
    logic [BW-1:0]     last_bit;
    logic [SRX_DW-1:0] data_now;
    logic              perr_now;

    // choose when a bit is sampled and when the data field ends
    always_comb begin
        bclk_rise  = bclk & ~bclk_q;
        limit      = (state == FR_START) ? MID : END;
        samp       = mode_1x ? bclk_rise : (tick16 && cnt == limit);
        start_seen = (mode_1x ? bclk_rise : tick16) && !line;
        last_bit   = eight_bit ? BW'(SRX_DW - 1) : BW'(SRX_DW - 2);
        data_now   = eight_bit ? shreg : {1'b0, shreg[SRX_DW-1:1]};
        perr_now   = par_en & (^data_now ^ pbit ^ par_odd);
    end

    // count tick16 pulses within the bit currently being received
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt <= '0;
        else if (en) begin
            if (clr || state == FR_IDLE)       cnt <= '0;
            else if (tick16)                   cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
        end
    end

    // remember the previous bit clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)  bclk_q <= 1'b0;
        else if (en) bclk_q <= bclk;
    end

    // frame state machine and character assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FR_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            ferr_q    <= 1'b0;
            push      <= 1'b0;
            push_char <= '0;
        end else if (en) begin
            push <= 1'b0;
            if (clr) begin
                state <= FR_IDLE;
            end else begin
                case (state)
                    FR_IDLE: if (start_seen) begin
                        state  <= mode_1x ? FR_DATA : FR_START;
                        bitcnt <= '0;
                    end
                    FR_START: if (samp) state <= line ? FR_IDLE : FR_DATA;
                    FR_DATA: if (samp) begin
                        shreg  <= {line, shreg[SRX_DW-1:1]};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == last_bit) state <= par_en ? FR_PAR : FR_STOP1;
                    end
                    FR_PAR: if (samp) begin
                        pbit  <= line;
                        state <= FR_STOP1;
                    end
                    FR_STOP1: if (samp) begin
                        ferr_q <= !line;
                        if (two_stop) begin
                            state <= FR_STOP2;
                        end else begin
                            state     <= FR_IDLE;
                            push      <= 1'b1;
                            push_char <= '{data: data_now, perr: perr_now, ferr: !line};
                        end
                    end
                    FR_STOP2: if (samp) begin
                        state     <= FR_IDLE;
                        push      <= 1'b1;
                        push_char <= '{data: data_now, perr: perr_now, ferr: ferr_q | !line};
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
// Character store. It is written by the framer and read from the head. A push
// into a full store is dropped and sets a sticky overrun flag. A pop clears
// overrun, and flush empties the store. Assumes DEPTH is a power of two.
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       flush,
    input  logic                       push,
    input  srx_char_t                  push_char,
    input  logic                       pop,
    output srx_char_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovr
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    srx_char_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;
    logic          is_full;

    // decide which requests are taken this cycle
    always_comb begin
        is_full = (level == LW'(DEPTH));
        do_push = push && !is_full;
        do_pop  = pop && level != '0;
    end

    // write accepted characters into storage
    always_ff @(posedge clk) begin
        if (en && !flush && do_push) mem[wr_ptr] <= push_char;
    end

    // pointers, fill level and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovr    <= 1'b0;
        end else if (en) begin
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                level  <= '0;
                ovr    <= 1'b0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + 1'b1;
                if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
                case ({do_push, do_pop})
                    2'b10:   level <= level + 1'b1;
                    2'b01:   level <= level - 1'b1;
                    default: level <= level;
                endcase
                if (push && is_full) ovr <= 1'b1;
                else if (do_pop)     ovr <= 1'b0;
            end
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/serial_rx_unit.sv
// Top of the serial receiver. It synchronizes the line and the bit clock and
// gates all state with unit_en. It routes the first read after reset to a
// clean start of the store, and derives the fill-level flags.
// Assumes tick16 is a single-cycle pulse in the clk domain.
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int OVS       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick16,
    input  logic              bit_clk,
    input  logic              unit_en,
    input  logic              rx_en,
    input  logic              mode_1x,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              eight_bit,
    input  logic              rd_stb,
    output logic [SRX_DW-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              ovr,
    output logic              rdy,
    output logic              half,
    output logic              full
);
    localparam int LW = $clog2(DEPTH + 1);

    logic          line_s;
    logic          bclk_s;
    logic          push;
    srx_char_t     push_char;
    srx_char_t     head;
    logic [LW-1:0] fifo_level;
    logic          init_pending;
    logic          first_rd;

    srx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync_line (
        .clk(clk), .rst_n(rst_n), .en(unit_en), .d(rxd), .q(line_s)
    );

    srx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b0)) u_sync_bclk (
        .clk(clk), .rst_n(rst_n), .en(unit_en), .d(bit_clk), .q(bclk_s)
    );

    srx_framer #(.OVS(OVS)) u_framer (
        .clk(clk), .rst_n(rst_n), .en(unit_en), .clr(!rx_en),
        .mode_1x(mode_1x), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .eight_bit(eight_bit), .tick16(tick16),
        .line(line_s), .bclk(bclk_s), .push(push), .push_char(push_char)
    );

    // the first read strobe after reset starts the store clean
    always_comb first_rd = rd_stb && init_pending;

    // track whether the starting read has happened yet
    always_ff @(posedge clk) begin
        if (!rst_n)                   init_pending <= 1'b1;
        else if (unit_en && first_rd) init_pending <= 1'b0;
    end

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .en(unit_en),
        .flush(!rx_en || first_rd),
        .push(push), .push_char(push_char),
        .pop(rd_stb && !init_pending),
        .head(head), .level(fifo_level), .ovr(ovr)
    );

    // head record and fill-level flags
    always_comb begin
        rd_data = head.data;
        rd_perr = head.perr;
        rd_ferr = head.ferr;
        rdy     = (fifo_level != '0);
        half    = (fifo_level >= LW'(DEPTH / 2));
        full    = (fifo_level == LW'(DEPTH));
    end
endmodule

// File: rtl/srx_checker.sv
// Property checker for serial_rx_unit, attached by bind. It watches the
// ports and the store fill level.
module srx_checker #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       unit_en,
    input logic                       rx_en,
    input logic                       rd_stb,
    input logic                       rdy,
    input logic                       half,
    input logic                       full,
    input logic                       ovr,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> $stable(rdy) && $stable(half) && $stable(full) && $stable(ovr)); // R2
    AST_FLUSH_ON_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en && !rx_en |=> !rdy && !ovr); // R3
    AST_FLAG_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half && rdy); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH)); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en && rx_en && ovr && !rd_stb |=> ovr); // R11
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en && rx_en && full && !rd_stb |=> full); // R11
endmodule

bind serial_rx_unit srx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .rx_en(rx_en),
    .rd_stb(rd_stb), .rdy(rdy), .half(half), .full(full), .ovr(ovr),
    .fifo_level(fifo_level)
);

// File: tb/tb_serial_rx_unit.sv
// Self-checking bench: sweeps every framing configuration in both sampling
// modes, then exercises noise rejection, fill levels, overrun, freeze and flush.
module tb_serial_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick16;
    logic       bit_clk;
    logic       unit_en = 1'b0, rx_en = 1'b0, mode_1x = 1'b0, par_en = 1'b0;
    logic       par_odd = 1'b0, two_stop = 1'b0, eight_bit = 1'b0, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, ovr, rdy, half, full;
    logic [1:0] tcnt = '0;
    logic [4:0] bcnt = '0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    // stimulus clocks move on the falling edge, away from sampling
    always @(negedge clk) begin
        tcnt <= tcnt + 1'b1;
        bcnt <= bcnt + 1'b1;
    end
    assign tick16  = (tcnt == 2'd3);
    assign bit_clk = bcnt[4];

    serial_rx_unit dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .bit_clk(bit_clk),
        .unit_en(unit_en), .rx_en(rx_en), .mode_1x(mode_1x), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop), .eight_bit(eight_bit),
        .rd_stb(rd_stb), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .ovr(ovr), .rdy(rdy), .half(half), .full(full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        if (mode_1x) begin
            @(negedge bit_clk);
            rxd = b;
        end else begin
            rxd = b;
            repeat (64) @(negedge clk);
        end
    endtask

    // build a frame from the current configuration and drive it on the line
    task automatic send(input logic [7:0] d, input logic badp, input logic bads);
        logic [15:0] bits;
        int          n;
        logic [7:0]  dm;
        dm = eight_bit ? d : (d & 8'h7f);
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < (eight_bit ? 8 : 7); i++) begin bits[n] = dm[i]; n++; end
        if (par_en) begin bits[n] = (^dm) ^ par_odd ^ badp; n++; end
        bits[n] = ~bads; n++;
        if (two_stop) begin bits[n] = 1'b1; n++; end
        bits[n] = 1'b1; n++;
        for (int i = 0; i < n; i++) drive_bit(bits[i]);
        if (mode_1x) @(negedge bit_clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", {rdy, half, full, ovr}, 4'b0000);

        unit_en = 1'b1; rx_en = 1'b1; eight_bit = 1'b1;
        send(8'h11, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0);
        chk("R12 stored before start read", rdy, 1'b1);
        pop();
        chk("R12 start read empties store", rdy, 1'b0);

        // full configuration sweep: R4 R6 R7 R8 R9
        for (int cfg = 0; cfg < 32; cfg++) begin
            logic [7:0] d, dm;
            logic       bp, bs;
            mode_1x = cfg[4]; eight_bit = cfg[3]; par_en = cfg[2];
            par_odd = cfg[1]; two_stop = cfg[0];
            d  = 8'h3c + 8'(cfg * 29);
            bp = (cfg % 3 == 1);
            bs = (cfg % 5 == 2);
            dm = eight_bit ? d : (d & 8'h7f);
            @(negedge clk);
            send(d, bp, bs);
            chk(mode_1x ? "R6 char ready" : "R4 char ready", rdy, 1'b1);
            chk("R7 data", rd_data, dm);
            chk("R8 parity flag", rd_perr, par_en & bp);
            chk("R9 framing flag", rd_ferr, bs);
            pop();
            chk("R10 store empty after read", rdy, 1'b0);
        end

        // start glitch in 16x mode, then a good frame
        mode_1x = 1'b0; eight_bit = 1'b1; par_en = 1'b0; two_stop = 1'b0;
        @(negedge clk);
        rxd = 1'b0; repeat (12) @(negedge clk);
        rxd = 1'b1; repeat (256) @(negedge clk);
        chk("R5 glitch rejected", rdy, 1'b0);
        send(8'h5a, 1'b0, 1'b0);
        chk("R5 receives after glitch", rd_data, 8'h5a);
        pop();

        // fill levels and overrun
        mode_1x = 1'b1;
        for (int k = 0; k < 9; k++) begin
            send(8'h10 + 8'(k), 1'b0, 1'b0);
            if (k == 2) chk("R10 half clear at 3", half, 1'b0);
            if (k == 3) chk("R10 half set at 4", half, 1'b1);
            if (k == 6) chk("R10 full clear at 7", full, 1'b0);
            if (k == 7) chk("R10 full set at 8, no ovr", {full, ovr}, 2'b10);
            if (k == 8) chk("R11 overrun set, still full", {full, ovr}, 2'b11);
        end
        for (int i = 0; i < 8; i++) begin
            chk("R10 order", rd_data, 8'h10 + 8'(i));
            pop();
            if (i == 0) chk("R11 overrun cleared by read", ovr, 1'b0);
        end
        chk("R11 dropped char absent", rdy, 1'b0);

        // freeze while the unit is off
        send(8'ha1, 1'b0, 1'b0);
        send(8'hb2, 1'b0, 1'b0);
        @(negedge clk); unit_en = 1'b0;
        rx_en = 1'b0;
        pop();
        send(8'hc3, 1'b0, 1'b0);
        chk("R2 frozen flags", {rdy, rd_data}, {1'b1, 8'ha1});
        rx_en = 1'b1; @(negedge clk);
        unit_en = 1'b1; repeat (4) @(negedge clk);
        chk("R2 head kept", rd_data, 8'ha1);
        pop();
        chk("R2 second kept", {rdy, rd_data}, {1'b1, 8'hb2});
        pop();
        chk("R2 nothing extra", rdy, 1'b0);

        // flush and ignore the line while reception is off
        send(8'hd4, 1'b0, 1'b0);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        chk("R3 flushed", rdy, 1'b0);
        send(8'he5, 1'b0, 1'b0);
        rx_en = 1'b1; repeat (4) @(negedge clk);
        chk("R3 line ignored", rdy, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule